// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block sits behind an external dual-modulus prescaler and brings the prescaler's output clock down to the comparison rate of a phase detector. Every rising edge of its clock is one prescaler output pulse. Within each count cycle, a 4-bit swallow count sets how many of those pulses the prescaler spends at the higher ratio N+1. A 15-bit main count sets the cycle length in prescaler pulses. The block's modulus-control output tells the prescaler which ratio to use. It issues one pulse per cycle toward the phase detector.

A single mode input picks the prescaler pair: N = 8 (8/9) or N = 16 (16/17). The input frequency is then divided by M·N + A. The programmed swallow value, main value and mode are sampled only at the boundary between cycles, so software may rewrite them at any time without disturbing a cycle already under way. A program with M below A is flagged rather than silently producing a wrong ratio.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high the pulse index is held at 0 and the configuration is loaded from the inputs. On the first edge after release, that pulse is pulse 0 of a cycle: `mod_hi` is 1 exactly when the effective A is non-zero, and `div_pulse` is 0 unless the effective M is 1.
- R2: Number the pulses of a cycle 0 to M-1. `mod_hi` is 1 on pulses 0 to A-1 and 0 on pulses A to M-1. 1 selects N+1 and 0 selects N.
- R3: `div_pulse` is 1 on pulse M-1 only, so it is one clock wide and each cycle lasts M pulses. A programmed M of 0 acts as M = 1.
- R4: Summing N+1 for each pulse with `mod_hi` = 1 and N for each other pulse gives M·N + A input clocks per cycle. N is 8 when `mode16` = 0 and 16 when `mode16` = 1.
- R5: With `mode16` = 0, bit 3 of `a_prog` is ignored, so the effective A is `a_prog` & 7.
- R6: Changes to `a_prog`, `m_prog` and `mode16` during a cycle have no effect on that cycle. The values present at the edge that ends pulse M-1 govern the next cycle.
- R7: If the effective M is below the effective A, `cfg_err` is 1 for the whole cycle and `mod_hi` stays 1 on all M pulses. Otherwise `cfg_err` is 0.
- R8: The extremes are reached exactly. M = 7, A = 0 in 8/9 mode gives 56. M = 32767, A = 15 in 16/17 mode gives 524287.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pre | input | 1 | Prescaler output clock, one edge per prescaler pulse |
| rst | input | 1 | Synchronous reset, active high |
| a_prog | input | 4 | Programmed swallow count A |
| m_prog | input | 15 | Programmed main count M |
| mode16 | input | 1 | 0 selects the 8/9 prescaler, 1 selects 16/17 |
| mod_hi | output | 1 | Modulus control: 1 requests N+1, 0 requests N |
| div_pulse | output | 1 | One-clock pulse on the last pulse of each cycle |
| cfg_err | output | 1 | The configuration of the current cycle has M below A |

## Verification
The hardest conditions to reach are the ones that depend on when an input changes relative to a cycle boundary. The bench rewrites all three programming inputs with random values on the first pulse of many cycles. It then sets the intended next words only on the final pulse, so any early capture shows up as a wrong swallow count or cycle length. Configurations with M below A, an M of zero, the masked A MSB in 8/9 mode and the full 32767-pulse cycle are each reached by directed cycles between the random ones.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int A_W = 4;
  localparam int M_W = 15;
  localparam int R_W = M_W + 5;
  localparam int N_SMALL = 8;
  localparam int N_LARGE = 16;

  // Effective swallow value: in the small-prescaler mode the MSB is dropped.
  function automatic logic [A_W-1:0] eff_swallow(input logic [A_W-1:0] a, input logic wide);
    logic [A_W-1:0] r;
    r = a;
    if (!wide) r[A_W-1] = 1'b0;
    return r;
  endfunction

  // Effective main value: zero is treated as a one-pulse cycle.
  function automatic logic [M_W-1:0] eff_main(input logic [M_W-1:0] m);
    return (m == '0) ? M_W'(1) : m;
  endfunction

  function automatic logic cfg_bad(input logic [A_W-1:0] a, input logic [M_W-1:0] m);
    return m < {{(M_W-A_W){1'b0}}, a};
  endfunction

  function automatic logic [R_W-1:0] base_n(input logic wide);
    return wide ? R_W'(N_LARGE) : R_W'(N_SMALL);
  endfunction

  // Input clocks per cycle for a legal configuration.
  function automatic logic [R_W-1:0] total_ratio(input logic [A_W-1:0] a,
                                                 input logic [M_W-1:0] m,
                                                 input logic wide);
    return R_W'(m) * base_n(wide) + R_W'(a);
  endfunction
endpackage

// File: rtl/swallow_cfg_latch.sv
module swallow_cfg_latch
  import swallow_pkg::*;
#(
  parameter int AW = swallow_pkg::A_W,
  parameter int MW = swallow_pkg::M_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] a_in,
  input  logic [MW-1:0] m_in,
  input  logic          wide_in,
  output logic [AW-1:0] a_w,
  output logic [MW-1:0] m_w,
  output logic          wide_w,
  output logic          bad_w
);
  always_ff @(posedge clk) begin
    if (rst || load) begin
      a_w    <= eff_swallow(a_in, wide_in);
      m_w    <= eff_main(m_in);
      wide_w <= wide_in;
      bad_w  <= cfg_bad(eff_swallow(a_in, wide_in), eff_main(m_in));
    end
  end

  // R5: small-prescaler mode never carries a swallow MSB
  a_r5_msb_masked: assert property (@(posedge clk) disable iff (rst)
    !wide_w |-> !a_w[AW-1]);

  // R6: working words only move on a boundary
  a_r6_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(a_w) && $stable(m_w) && $stable(wide_w)));

  // R3: the working main count is never zero
  a_r3_main_nonzero: assert property (@(posedge clk) disable iff (rst)
    m_w != '0);
endmodule

// File: rtl/swallow_pulse_count.sv
module swallow_pulse_count #(
  parameter int MW = swallow_pkg::M_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] m_w,
  output logic [MW-1:0] idx,
  output logic          cyc_start,
  output logic          cyc_end
);
  localparam logic [MW-1:0] ONE = MW'(1);

  assign cyc_start = (idx == '0);
  assign cyc_end   = (idx == m_w - ONE);

  always_ff @(posedge clk) begin
    if (rst || cyc_end) idx <= '0;
    else                idx <= idx + ONE;
  end

  // R3: the index never passes the cycle length
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    idx < m_w);

  // R3: after a cycle end the next pulse is pulse 0
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> cyc_start);
endmodule

// File: rtl/swallow_mod_ctrl.sv
module swallow_mod_ctrl #(
  parameter int AW = swallow_pkg::A_W,
  parameter int MW = swallow_pkg::M_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] idx,
  input  logic          cyc_start,
  input  logic [AW-1:0] a_w,
  input  logic          bad_w,
  output logic          mod_hi
);
  logic [MW-1:0] a_ext;
  assign a_ext  = {{(MW-AW){1'b0}}, a_w};
  assign mod_hi = (idx < a_ext) || bad_w;

  // R7: a bad configuration never drops to the lower ratio
  a_r7_bad_stays_high: assert property (@(posedge clk) disable iff (rst)
    bad_w |-> mod_hi);

  // R2: once low inside a cycle, the modulus stays low until the next start
  a_r2_no_reraise: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start && $past(!mod_hi)) |-> !mod_hi);

  // R2: a non-zero swallow count starts every cycle at N+1
  a_r2_start_high: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && a_w != '0) |-> mod_hi);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_pkg::*;
(
  input  logic           clk_pre,
  input  logic           rst,
  input  logic [A_W-1:0] a_prog,
  input  logic [M_W-1:0] m_prog,
  input  logic           mode16,
  output logic           mod_hi,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic [A_W-1:0] a_w;
  logic [M_W-1:0] m_w;
  logic           wide_w;
  logic           bad_w;
  logic [M_W-1:0] idx;
  logic           cyc_start;
  logic           cyc_end;

  swallow_cfg_latch #(.AW(A_W), .MW(M_W)) u_cfg (
    .clk(clk_pre), .rst(rst), .load(cyc_end),
    .a_in(a_prog), .m_in(m_prog), .wide_in(mode16),
    .a_w(a_w), .m_w(m_w), .wide_w(wide_w), .bad_w(bad_w)
  );

  swallow_pulse_count #(.MW(M_W)) u_cnt (
    .clk(clk_pre), .rst(rst), .m_w(m_w),
    .idx(idx), .cyc_start(cyc_start), .cyc_end(cyc_end)
  );

  swallow_mod_ctrl #(.AW(A_W), .MW(M_W)) u_mod (
    .clk(clk_pre), .rst(rst), .idx(idx), .cyc_start(cyc_start),
    .a_w(a_w), .bad_w(bad_w), .mod_hi(mod_hi)
  );

  assign div_pulse = cyc_end;
  assign cfg_err   = bad_w;

  // Input-clock accumulator for the ratio assertion only.
  logic [R_W-1:0] in_acc;
  logic [R_W-1:0] in_acc_now;
  assign in_acc_now = in_acc + base_n(wide_w) + (mod_hi ? R_W'(1) : R_W'(0));

  always_ff @(posedge clk_pre) begin
    if (rst || cyc_end) in_acc <= '0;
    else                in_acc <= in_acc_now;
  end

  // R4: a legal cycle spans exactly M*N+A input clocks
  a_r4_ratio: assert property (@(posedge clk_pre) disable iff (rst)
    (cyc_end && !bad_w) |-> (in_acc_now == total_ratio(a_w, m_w, wide_w)));

  // R3: the divided output is one clock wide unless M is 1
  a_r3_one_wide: assert property (@(posedge clk_pre) disable iff (rst)
    div_pulse |=> (!div_pulse || m_w == M_W'(1)));

  // R1: released from reset at pulse 0
  a_r1_first_pulse: assert property (@(posedge clk_pre)
    $fell(rst) |-> cyc_start);
endmodule

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
  logic        clk_pre = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  a_prog = '0;
  logic [14:0] m_prog = 15'd1;
  logic        mode16 = 1'b0;
  logic        mod_hi, div_pulse, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  swallow_divider uut (
    .clk_pre(clk_pre), .rst(rst), .a_prog(a_prog), .m_prog(m_prog),
    .mode16(mode16), .mod_hi(mod_hi), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always #2.5 clk_pre = ~clk_pre;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ea(input int a, input int md);
    return md ? a : (a & 7);
  endfunction
  function automatic int em(input int m);
    return (m == 0) ? 1 : m;
  endfunction

  // Entered on the negedge where pulse 0 of the cycle is shown; leaves on the
  // negedge of the next cycle's pulse 0.
  task automatic run_cycle(input int ca, input int cm, input int cmd,
                           input int na, input int nm, input int nmd,
                           input bit scramble, input string tag);
    int a_e, m_e, n_b, swallowed, miss;
    longint acc;
    bit bad;
    a_e = ea(ca, cmd);
    m_e = em(cm);
    n_b = cmd ? 16 : 8;
    bad = (m_e < a_e);
    swallowed = 0; miss = 0; acc = 0;
    for (int k = 0; k < m_e; k++) begin
      bit xm, xd;
      xm = (k < a_e) || bad;
      xd = (k == m_e - 1);
      if (mod_hi !== xm) begin
        miss++;
        chk(0, "R2", "mod_hi", mod_hi, xm);
      end
      if (div_pulse !== xd) begin
        miss++;
        chk(0, "R3", "div_pulse", div_pulse, xd);
      end
      if (cfg_err !== bad) begin
        miss++;
        chk(0, "R7", "cfg_err", cfg_err, bad);
      end
      if (mod_hi === 1'b1) swallowed++;
      acc += (mod_hi === 1'b1) ? n_b + 1 : n_b;
      if (k == m_e - 1) begin
        a_prog = 4'(na); m_prog = 15'(nm); mode16 = nmd[0];
      end else if (scramble && k == 0) begin
        a_prog = 4'($urandom); m_prog = 15'($urandom); mode16 = 1'($urandom);
      end
      @(negedge clk_pre);
    end
    chk(miss == 0, "R2", "per-pulse mismatches", miss, 0);
    chk(swallowed == (bad ? m_e : a_e), tag, "N+1 pulses", swallowed, bad ? m_e : a_e);
    if (!bad) chk(acc == longint'(m_e) * n_b + a_e, tag, "input clocks", acc,
                  longint'(m_e) * n_b + a_e);
    else chk(acc == longint'(m_e) * (n_b + 1), "R7", "input clocks", acc,
             longint'(m_e) * (n_b + 1));
    if (scramble) chk(miss == 0, "R6", "cycle disturbed", miss, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      chk(0, "WD", "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ca, cm, cd, na, nm, nd;
    void'($urandom(32'd1357));
    // R1: reset state
    a_prog = 4'd3; m_prog = 15'd10; mode16 = 1'b0; rst = 1'b1;
    repeat (3) @(posedge clk_pre);
    @(negedge clk_pre);
    chk(mod_hi === 1'b1, "R1", "mod_hi in reset", mod_hi, 1);
    chk(div_pulse === 1'b0, "R1", "div_pulse in reset", div_pulse, 0);
    chk(cfg_err === 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
    rst = 1'b0;
    ca = 3; cm = 10; cd = 0;
    // R8: minimum ratio next
    run_cycle(ca, cm, cd, 0, 7, 0, 0, "R4");
    run_cycle(0, 7, 0, 15, 20, 0, 0, "R8");
    // R5: A MSB ignored in 8/9 mode (expects 7 swallowed pulses)
    run_cycle(15, 20, 0, 0, 0, 1, 1, "R5");
    // R3: M programmed as 0 acts as 1
    run_cycle(0, 0, 1, 9, 4, 1, 0, "R3");
    // R7: M below A
    run_cycle(9, 4, 1, 15, 15, 1, 1, "R7");
    run_cycle(15, 15, 1, 5, 30, 1, 1, "R4");
    ca = 5; cm = 30; cd = 1;
    for (int i = 0; i < 150; i++) begin
      na = $urandom_range(15); nd = $urandom_range(1);
      nm = ($urandom_range(9) == 0) ? $urandom_range(15) : $urandom_range(100);
      run_cycle(ca, cm, cd, na, nm, nd, (i % 2) == 0, "R4");
      ca = na; cm = nm; cd = nd;
    end
    run_cycle(ca, cm, cd, 15, 32767, 1, 0, "R4");
    // R8: maximum ratio
    run_cycle(15, 32767, 1, 2, 9, 0, 1, "R8");
    run_cycle(2, 9, 0, 2, 9, 0, 0, "R4");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule